// File: doc/BRIEF.md
# Reduced Permutation Enumeration Encoder

This block turns an ordering of K distinct input lanes into a short binary index. Each lane of the input carries a small number, and together the lanes hold every value from 0 to K-1 exactly once. An inversion-counting front end first derives one digit per lane except the last. That digit counts how many later lanes hold a smaller value. The digits then go to a packing stage. Most digits simply hand over their low bits. A fixed set of digit pairs is merged, because their joint range yields one bit more than the two digits give separately. No general multiplier is used: the only arithmetic is multiplication by a small constant and a truncation.

The index does not follow lexicographic order. What matters is that every value of the floor(log2 K!)-bit output is produced by at least one input ordering. A loader can then choose a lane ordering that regenerates any bit pattern it has left out of stored data. The result is registered once, so the block fits a pipelined datapath.

Top module: `perm_enum_encoder`

## Requirements
- R1: The output is floor(log2 K!) bits wide: 4 bits for K=4, 9 for K=6, 12 for K=7. The block supports K from 2 to 7.
- R2: Lane m of the input occupies bits [m*IW +: IW], where IW = clog2(K). Digit i, for i from 0 to K-2, is the number of lanes j > i whose value is smaller than the value of lane i. Digit i therefore lies between 0 and K-1-i.
- R3: A digit that belongs to no pair contributes its floor(log2(K-i)) least significant bits unchanged.
- R4: The pairs are fixed for each K. There are none for K up to 5. For K=6 the pair is (3,0). For K=7 the pairs are (4,1) and (2,0).
- R5: A pair made of a higher digit h and a lower digit l contributes ((K-l)*h + l) mod 2^floor(log2((K-h)*(K-l))). That is 4 bits for (3,0) at K=6, 4 bits for (4,1) and 5 bits for (2,0) at K=7.
- R6: Fields are packed from bit 0 upward. Groups are taken in descending order of their highest digit index, and each field is placed least significant bit first. For K=6 the layout is: digit 4 at bit 0, pair (3,0) at bits 4:1, digit 2 at bits 6:5, digit 1 at bits 8:7.
- R7: The output shows the code for the input sampled at the previous rising clock edge, and it does not change between edges.
- R8: While the synchronous active-high reset is asserted at a rising edge, the output becomes zero.
- R9: Every one of the 2^floor(log2 K!) output codes is produced by at least one valid input ordering.
- R10: The identity ordering, where lane m holds m, produces code zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| perm_i | input | K*IW | Lane values, lane m at bits [m*IW +: IW] |
| enum_o | output | floor(log2 K!) | Registered enumeration code |

## Verification
The bench builds three copies of the block: K=4, where no pair is merged; K=6, with a single merged pair; and K=7, with two pairs of different sizes. It walks every ordering of each copy, 24, 720 and 5040 of them. Each ordering is decoded from its digit vector in the bench, and the expected code is computed from the field layout of each K. Because every ordering is applied, the bench can also show that each K reaches all 16, 512 and 4096 codes. Reset, the one-edge latency and the identity case are checked on the K=6 copy.

// File: rtl/perm_enum_pkg.sv
package perm_enum_pkg;

    typedef enum logic [1:0] {
        GRP_SINGLE = 2'd0,
        GRP_HEAD   = 2'd1,
        GRP_TAIL   = 2'd2
    } grp_kind_e;

    function automatic int flog2(input longint v);
        longint t;
        int     b;
        t = v;
        b = 0;
        while (t > 1) begin
            t = t >> 1;
            b++;
        end
        return b;
    endfunction

    function automatic int fact_bits(input int k);
        longint f;
        f = 1;
        for (int n = 2; n <= k; n++) f = f * n;
        return flog2(f);
    endfunction

    // lower partner of a merged pair led by digit i, or -1
    function automatic int pair_low(input int k, input int i);
        case (k)
            6: return (i == 3) ? 0 : -1;
            7: begin
                if (i == 4) return 1;
                if (i == 2) return 0;
                return -1;
            end
            default: return -1;
        endcase
    endfunction

    function automatic grp_kind_e group_kind(input int k, input int i);
        for (int h = 0; h < k - 1; h++)
            if (pair_low(k, h) == i) return GRP_TAIL;
        if (pair_low(k, i) >= 0) return GRP_HEAD;
        return GRP_SINGLE;
    endfunction

    function automatic int group_bits(input int k, input int i);
        case (group_kind(k, i))
            GRP_TAIL: return 0;
            GRP_HEAD: return flog2(longint'((k - i) * (k - pair_low(k, i))));
            default:  return flog2(longint'(k - i));
        endcase
    endfunction

    // bit offset: groups led by higher digits come first
    function automatic int group_off(input int k, input int i);
        int s;
        s = 0;
        for (int h = k - 2; h > i; h--) s += group_bits(k, h);
        return s;
    endfunction

endpackage

// File: rtl/perm_lehmer_front.sv
module perm_lehmer_front #(
    parameter int K  = 6,
    parameter int IW = 3,
    parameter int DW = 3
) (
    input  logic [K*IW-1:0]     perm_i,
    output logic [(K-1)*DW-1:0] digits_o
);

    for (genvar gi = 0; gi < K - 1; gi++) begin : g_digit
        logic [K-1:0]  inv;
        logic [DW-1:0] cnt;

        // inversion indicators: later lane smaller than this lane
        for (genvar gj = 0; gj < K; gj++) begin : g_cmp
            if (gj > gi) begin : g_later
                assign inv[gj] = perm_i[gj*IW +: IW] < perm_i[gi*IW +: IW];
            end else begin : g_earlier
                assign inv[gj] = 1'b0;
            end
        end

        always_comb begin
            cnt = '0;
            for (int j = 0; j < K; j++)
                if (inv[j]) cnt = cnt + DW'(1);
        end

        assign digits_o[gi*DW +: DW] = cnt;
    end

endmodule

// File: rtl/perm_pair_merge.sv
module perm_pair_merge #(
    parameter int R_HI = 3,
    parameter int R_LO = 6,
    parameter int DW   = 3,
    parameter int OW   = 4,
    localparam int PW  = $clog2(R_HI * R_LO)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] hi_i,
    input  logic [DW-1:0] lo_i,
    output logic [OW-1:0] code_o
);

    logic [PW-1:0] joint;

    // mixed-radix value of the pair; constant factor only
    assign joint  = PW'(hi_i) * PW'(R_LO) + PW'(lo_i);
    assign code_o = joint[OW-1:0];

    // R5: with the higher digit at zero the lower digit appears unchanged
    p_merge_lo_pass_r5: assert property (@(posedge clk) disable iff (rst)
        (hi_i == '0) |-> (code_o == OW'(lo_i)));

    // R5: one step of the higher digit advances the code by the lower range
    p_merge_step_r5: assert property (@(posedge clk) disable iff (rst)
        (hi_i == DW'(1)) |-> (code_o == OW'(lo_i + DW'(R_LO))));

endmodule

// File: rtl/perm_code_pack.sv
module perm_code_pack
    import perm_enum_pkg::*;
#(
    parameter int K  = 6,
    parameter int DW = 3,
    parameter int EW = 9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [(K-1)*DW-1:0]  digits_i,
    output logic [EW-1:0]        code_o
);

    for (genvar gi = 0; gi < K - 1; gi++) begin : g_grp
        localparam grp_kind_e KIND = group_kind(K, gi);
        localparam int        B    = group_bits(K, gi);
        localparam int        OFF  = group_off(K, gi);

        if (KIND == GRP_SINGLE) begin : g_single
            assign code_o[OFF +: B] = digits_i[gi*DW +: B];
        end else if (KIND == GRP_HEAD) begin : g_head
            localparam int LO = pair_low(K, gi);
            perm_pair_merge #(
                .R_HI (K - gi),
                .R_LO (K - LO),
                .DW   (DW),
                .OW   (B)
            ) u_merge (
                .clk    (clk),
                .rst    (rst),
                .hi_i   (digits_i[gi*DW +: DW]),
                .lo_i   (digits_i[LO*DW +: DW]),
                .code_o (code_o[OFF +: B])
            );
        end

        // R2: each digit stays inside its range
        p_digit_range_r2: assert property (@(posedge clk) disable iff (rst)
            digits_i[gi*DW +: DW] <= DW'(K - 1 - gi));
    end

endmodule

// File: rtl/perm_enum_encoder.sv
module perm_enum_encoder
    import perm_enum_pkg::*;
#(
    parameter int  K  = 6,
    localparam int IW = $clog2(K),
    localparam int DW = IW,
    localparam int EW = fact_bits(K)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [K*IW-1:0] perm_i,
    output logic [EW-1:0] enum_o
);

    logic [(K-1)*DW-1:0] digits;
    logic [EW-1:0]       code_w;
    logic [EW-1:0]       enum_q;
    logic [K*IW-1:0]     ident_perm;

    perm_lehmer_front #(
        .K  (K),
        .IW (IW),
        .DW (DW)
    ) u_front (
        .perm_i   (perm_i),
        .digits_o (digits)
    );

    perm_code_pack #(
        .K  (K),
        .DW (DW),
        .EW (EW)
    ) u_pack (
        .clk      (clk),
        .rst      (rst),
        .digits_i (digits),
        .code_o   (code_w)
    );

    always_ff @(posedge clk) begin
        if (rst) enum_q <= '0;
        else     enum_q <= code_w;
    end

    assign enum_o = enum_q;

    always_comb begin
        for (int m = 0; m < K; m++) ident_perm[m*IW +: IW] = IW'(m);
    end

    // R8: first edge after reset shows a cleared output
    p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (enum_o == '0));

    // R10: identity ordering encodes to zero one edge later
    p_ident_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (perm_i == ident_perm) |=> (enum_o == '0));

    // R7: an unchanged input keeps the output unchanged
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (perm_i == $past(perm_i))) |=> $stable(enum_o));

endmodule

// File: tb/perm_enum_encoder_tb.sv
`timescale 1ns/1ps
module perm_enum_encoder_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  perm4 = 8'b11_10_01_00;
    logic [17:0] perm6 = 18'o543210;
    logic [20:0] perm7 = 21'o6543210;
    logic [3:0]  e4;
    logic [8:0]  e6;
    logic [11:0] e7;

    int total = 0;
    int bad   = 0;
    bit seen [0:4095];

    always #4 clk = ~clk;

    perm_enum_encoder #(.K(6)) u_dut    (.clk(clk), .rst(rst), .perm_i(perm6), .enum_o(e6));
    perm_enum_encoder #(.K(7)) u_dut_k7 (.clk(clk), .rst(rst), .perm_i(perm7), .enum_o(e7));
    perm_enum_encoder #(.K(4)) u_dut_k4 (.clk(clk), .rst(rst), .perm_i(perm4), .enum_o(e4));

    task automatic check(input bit ok, input string req, input int got, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    // expected code from digits, per the field layouts of R3..R6
    function automatic int expect_code(input int k, input int d[8]);
        case (k)
            4: return (d[2] & 1) | ((d[1] & 1) << 1) | ((d[0] & 3) << 2);
            6: return (d[4] & 1) | (((6*d[3] + d[0]) % 16) << 1)
                    | ((d[2] & 3) << 5) | ((d[1] & 3) << 7);
            7: return (d[5] & 1) | (((6*d[4] + d[1]) % 16) << 1)
                    | ((d[3] & 3) << 5) | (((7*d[2] + d[0]) % 32) << 7);
            default: return -1;
        endcase
    endfunction

    // ordering index n -> digits -> lane values packed per R2
    task automatic build(input int k, input int n, output int d[8], output logic [31:0] vec);
        int rem;
        int iw;
        bit used [8];
        rem = n;
        iw  = (k == 4) ? 2 : 3;
        for (int i = k - 1; i >= 0; i--) begin
            d[i] = rem % (k - i);
            rem  = rem / (k - i);
        end
        for (int i = 0; i < 8; i++) used[i] = 1'b0;
        vec = '0;
        for (int i = 0; i < k; i++) begin
            int skip;
            skip = d[i];
            for (int v = 0; v < k; v++) begin
                if (!used[v]) begin
                    if (skip == 0) begin
                        used[v] = 1'b1;
                        vec = vec | (32'(v) << (i * iw));
                        skip = -1;
                    end else if (skip > 0) begin
                        skip--;
                    end
                end
            end
        end
    endtask

    task automatic apply(input int k, input logic [31:0] vec);
        case (k)
            4: perm4 = vec[7:0];
            6: perm6 = vec[17:0];
            default: perm7 = vec[20:0];
        endcase
    endtask

    function automatic int read_out(input int k);
        case (k)
            4: return int'(e4);
            6: return int'(e6);
            default: return int'(e7);
        endcase
    endfunction

    task automatic sweep(input int k);
        int fact;
        int w;
        int missing;
        fact = 1;
        for (int n = 2; n <= k; n++) fact = fact * n;
        w = (k == 4) ? 4 : (k == 6) ? 9 : 12;
        for (int c = 0; c < 4096; c++) seen[c] = 1'b0;
        for (int n = 0; n < fact; n++) begin
            int          d[8];
            logic [31:0] vec;
            int          got;
            int          exp;
            build(k, n, d, vec);
            apply(k, vec);
            @(negedge clk);
            got = read_out(k);
            exp = expect_code(k, d);
            check(got == exp, $sformatf("R2/R3/R4/R5/R6 k=%0d n=%0d", k, n), got, exp);
            if (got >= 0 && got < 4096) seen[got] = 1'b1;
        end
        missing = 0;
        for (int c = 0; c < (1 << w); c++) if (!seen[c]) missing++;
        check(missing == 0, $sformatf("R9 k=%0d missing codes", k), missing, 0);
    endtask

    initial begin
        int          d[8];
        logic [31:0] vec;
        int          rev6;

        // R1: output widths
        check($bits(u_dut.enum_o) == 9,     "R1 k=6 width", $bits(u_dut.enum_o), 9);
        check($bits(u_dut_k7.enum_o) == 12, "R1 k=7 width", $bits(u_dut_k7.enum_o), 12);
        check($bits(u_dut_k4.enum_o) == 4,  "R1 k=4 width", $bits(u_dut_k4.enum_o), 4);

        // reversed ordering held while in reset: digits are 5,4,3,2,1
        build(6, 719, d, vec);
        rev6 = expect_code(6, d);
        apply(6, vec);
        repeat (3) @(negedge clk);
        check(e6 == 9'd0, "R8 k=6 reset clears", int'(e6), 0);
        check(e7 == 12'd0, "R8 k=7 reset clears", int'(e7), 0);

        rst = 1'b0;
        @(negedge clk);
        check(int'(e6) == rev6, "R7 reversed after one edge", int'(e6), rev6);

        // R7: a new input does not show before the next edge
        build(6, 0, d, vec);
        apply(6, vec);
        #1;
        check(int'(e6) == rev6, "R7 holds until edge", int'(e6), rev6);
        @(negedge clk);
        check(e6 == 9'd0, "R10 identity gives zero", int'(e6), 0);

        // R8: reset in mid-run with a nonzero code pending
        build(6, 719, d, vec);
        apply(6, vec);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(e6 == 9'd0, "R8 mid-run reset", int'(e6), 0);
        rst = 1'b0;
        @(negedge clk);
        check(int'(e6) == rev6, "R7 after reset release", int'(e6), rev6);

        sweep(4);
        sweep(6);
        sweep(7);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R7 watchdog expired got=%0d exp=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule